// File: doc/BRIEF.md
# Three-Phase Triangle-Wave PWM Timer

This block is a triangle-wave timer for driving three complementary PWM phase pairs. A counter climbs from zero toward a programmed period value. It goes exactly one step past that value, then counts back down to zero and turns upward again. Each phase compares the running count against its own active compare value. The phase output is high while the count is above that value, and the companion output is always the opposite level.

Every active compare value has a shadow buffer behind it. When the transfer-mode field is set to 3, the block copies all three buffers into the active compare registers in a single clock. That copy happens only on the upward step from the period value to one above it, which is the same step that sets a sticky match flag. The descending pass through the period value does not copy the buffers and does not touch the flag.

Software reaches the block through a plain single-cycle register bus. Writes are strobed and reads are combinational, so the bus has no back-pressure and no valid/ready handshake. The count enable, the flag and the phase pins are plain level signals.

Top module: `tripwm_timer`

## Requirements
- R1: The count changes by exactly one on each clock where `cnt_en` is high. When `cnt_en` is low, the count and the direction both hold.
- R2: The period must be below 2^CNT_W-1. With the period at m, the count around the top of the wave runs m-1, m, m+1, m, m-1. On the step into m+1 the direction turns to down.
- R3: When counting down, the count goes 1 then 0, and the next enabled step is 1 with the direction turned to up. A period of 0 therefore gives the sequence 0, 1, 0, 1.
- R4: `match_flag` is set on the enabled clock where the count steps up from the period value to period+1. Nothing else sets it, and the descending pass through the period value leaves it unchanged.
- R5: `match_flag` stays at 1 until a control write (address 7) with bit 2 at 0 clears it. A control write with bit 2 at 1 leaves the flag as it was. When a clear and a set event fall on the same clock, the flag is 1 afterwards.
- R6: The transfer mode is control bits [1:0]. When the mode is 3, each buffer (addresses 4, 5, 6) is copied into its compare register (addresses 1, 2, 3) on the clock that sets the flag. The copy takes the buffer value held before that clock, and it wins over a direct compare write made on the same clock.
- R7: The buffers are never copied at the bottom turnaround, never on the descending pass, and never at all while the mode is not 3. A direct write to a compare register takes effect on the next clock.
- R8: `phase_hi[i]` is 1 exactly when the count is greater than compare register i. `phase_lo[i]` is always the inverse of `phase_hi[i]`.
- R9: Reset clears the count to 0, sets the direction to up, and clears the flag. It also clears the period, the compare registers, the buffers and the mode to 0.
- R10: Address map:
  - 0: period
  - 1 to 3: compare registers
  - 4 to 6: buffers
  - 7: control, with the flag at bit 2 and the mode at bits [1:0]
  - 8: count, read-only

  `rdata` follows `addr` in the same cycle. Any other address reads 0, and writes to it are ignored.
- R11: If the period is written below the count while the counter is going up, the counter turns down at once. It counts down from where it stands and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data |
| match_flag | output | 1 | Sticky top-match flag |
| phase_hi | output | 3 | Phase outputs, high while count > compare |
| phase_lo | output | 3 | Complementary phase outputs |

## Verification
The hardest cases to reach are the collisions on the clock of the top step. These are a flag clear arriving on the very edge that sets the flag, and a direct compare write or buffer write landing on the same edge as the automatic transfer. The bench keeps a behavioural model of the counter and uses that model's state to find the cycle where the count equals the period and is rising. It issues the bus write in exactly that cycle. The same method times a period reduction so that it lands while the count is already above the new value.

// File: rtl/tripwm_pkg.sv
package tripwm_pkg;
  localparam int ADDR_W   = 4;
  localparam int N_PHASE  = 3;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd1;
  localparam logic [ADDR_W-1:0] A_BUF0   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd7;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd8;
  localparam int FLAG_BIT = 2;
  localparam logic [1:0] MODE_TOP_XFER = 2'b11;
endpackage

// File: rtl/tpw_counter.sv
module tpw_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         top_hit
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_nx;
  logic         up_nx;

  assign top_hit = en && dir_up && (cnt == period);

  always_comb begin
    cnt_nx = cnt;
    up_nx  = dir_up;
    if (en) begin
      if (dir_up) begin
        if (cnt < period) begin
          cnt_nx = cnt + ONE;
        end else if (cnt == period) begin
          cnt_nx = cnt + ONE;
          up_nx  = 1'b0;
        end else begin
          cnt_nx = cnt - ONE;
          up_nx  = 1'b0;
        end
      end else begin
        if (cnt > ONE) begin
          cnt_nx = cnt - ONE;
        end else if (cnt == ONE) begin
          cnt_nx = '0;
          up_nx  = 1'b1;
        end else begin
          cnt_nx = ONE;
          up_nx  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_nx;
      dir_up <= up_nx;
    end
  end
endmodule

// File: rtl/tpw_cmp_bank.sv
module tpw_cmp_bank #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer,
  input  logic [N-1:0]        wr_cmp,
  input  logic [N-1:0]        wr_buf,
  input  logic [W-1:0]        wdata,
  input  logic [W-1:0]        cnt,
  output logic [N-1:0][W-1:0] cmp_q,
  output logic [N-1:0][W-1:0] buf_q,
  output logic [N-1:0]        hi,
  output logic [N-1:0]        lo
);
  for (genvar g = 0; g < N; g++) begin : g_phase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[g] <= '0;
        buf_q[g] <= '0;
      end else begin
        if (xfer)           cmp_q[g] <= buf_q[g];
        else if (wr_cmp[g]) cmp_q[g] <= wdata;
        if (wr_buf[g])      buf_q[g] <= wdata;
      end
    end
    assign hi[g] = cnt > cmp_q[g];
    assign lo[g] = ~hi[g];
  end
endmodule

// File: rtl/tripwm_timer.sv
module tripwm_timer
  import tripwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_en,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CNT_W-1:0]         wdata,
  output logic [CNT_W-1:0]         rdata,
  output logic                     match_flag,
  output logic [N_PHASE-1:0]       phase_hi,
  output logic [N_PHASE-1:0]       phase_lo
);
  logic [CNT_W-1:0]              period_q;
  logic [1:0]                    mode_q;
  logic [CNT_W-1:0]              cnt;
  logic                          dir_up;
  logic                          top_hit;
  logic                          xfer;
  logic [N_PHASE-1:0]            wr_cmp;
  logic [N_PHASE-1:0]            wr_buf;
  logic [N_PHASE-1:0][CNT_W-1:0] cmp_q;
  logic [N_PHASE-1:0][CNT_W-1:0] buf_q;
  logic                          wr_ctrl;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign xfer    = top_hit && (mode_q == MODE_TOP_XFER);

  for (genvar g = 0; g < N_PHASE; g++) begin : g_dec
    assign wr_cmp[g] = wr_en && (addr == A_CMP0 + ADDR_W'(g));
    assign wr_buf[g] = wr_en && (addr == A_BUF0 + ADDR_W'(g));
  end

  tpw_counter #(.W(CNT_W)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en),
    .period  (period_q),
    .cnt     (cnt),
    .dir_up  (dir_up),
    .top_hit (top_hit)
  );

  tpw_cmp_bank #(.W(CNT_W), .N(N_PHASE)) bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .xfer   (xfer),
    .wr_cmp (wr_cmp),
    .wr_buf (wr_buf),
    .wdata  (wdata),
    .cnt    (cnt),
    .cmp_q  (cmp_q),
    .buf_q  (buf_q),
    .hi     (phase_hi),
    .lo     (phase_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q   <= '0;
      mode_q     <= '0;
      match_flag <= 1'b0;
    end else begin
      if (wr_en && addr == A_PERIOD) period_q <= wdata;
      if (wr_ctrl) mode_q <= wdata[1:0];
      if (top_hit)                       match_flag <= 1'b1;
      else if (wr_ctrl && !wdata[FLAG_BIT]) match_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_PERIOD) begin
      rdata = period_q;
    end else if (addr == A_CTRL) begin
      rdata[1:0]      = mode_q;
      rdata[FLAG_BIT] = match_flag;
    end else if (addr == A_COUNT) begin
      rdata = cnt;
    end else begin
      for (int i = 0; i < N_PHASE; i++) begin
        if (addr == A_CMP0 + ADDR_W'(i)) rdata = cmp_q[i];
        if (addr == A_BUF0 + ADDR_W'(i)) rdata = buf_q[i];
      end
    end
  end
endmodule

// File: rtl/tpw_chk.sv
module tpw_chk
  import tripwm_pkg::*;
#(
  parameter int W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cnt_en,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [W-1:0]             wdata,
  input logic                     match_flag,
  input logic [W-1:0]             cnt,
  input logic                     dir_up,
  input logic [W-1:0]             period_q,
  input logic [1:0]               mode_q,
  input logic [N_PHASE-1:0][W-1:0] cmp_q,
  input logic [N_PHASE-1:0][W-1:0] buf_q
);
  localparam logic [W-1:0] ONE = W'(1);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt) && $stable(dir_up)));

  // R2
  top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dir_up && cnt == period_q) |=> (cnt == $past(cnt) + ONE && !dir_up));

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(cnt_en && dir_up && cnt == period_q));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !(wr_en && addr == A_CTRL && !wdata[FLAG_BIT])) |=> match_flag);

  // R6
  top_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dir_up && cnt == period_q && mode_q == MODE_TOP_XFER) |=> (cmp_q == $past(buf_q)));

  // R7
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_TOP_XFER && !(wr_en && addr >= 4'd1 && addr <= 4'd3)) |=> $stable(cmp_q));
endmodule

bind tripwm_timer tpw_chk #(.W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_en     (cnt_en),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .match_flag (match_flag),
  .cnt        (cnt),
  .dir_up     (dir_up),
  .period_q   (period_q),
  .mode_q     (mode_q),
  .cmp_q      (cmp_q),
  .buf_q      (buf_q)
);

// File: tb/tripwm_timer_tb_top.sv
module tripwm_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cnt_en;
  logic         wr_en;
  logic [3:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         match_flag;
  logic [2:0]   phase_hi;
  logic [2:0]   phase_lo;

  always #4 clk = ~clk;

  tripwm_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .match_flag(match_flag),
    .phase_hi(phase_hi), .phase_lo(phase_lo)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R9";
  bit done = 0;

  int m_per, m_mode, m_cnt;
  bit m_up, m_flag;
  int m_cmp[3];
  int m_buf[3];
  int t_cnt, t_per, t_mode;
  bit t_up, t_flag, t_set;
  int t_cmp[3];
  int t_buf[3];

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    if (a == 0) return m_per;
    if (a >= 1 && a <= 3) return m_cmp[a-1];
    if (a >= 4 && a <= 6) return m_buf[a-4];
    if (a == 7) return m_mode + (m_flag ? 4 : 0);
    if (a == 8) return m_cnt;
    return 0;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = 0; m_mode = 0; m_cnt = 0; m_up = 1; m_flag = 0;
      for (int i = 0; i < 3; i++) begin m_cmp[i] = 0; m_buf[i] = 0; end
    end else begin
      t_cnt = m_cnt; t_up = m_up; t_per = m_per; t_mode = m_mode; t_flag = m_flag;
      for (int i = 0; i < 3; i++) begin t_cmp[i] = m_cmp[i]; t_buf[i] = m_buf[i]; end
      t_set = cnt_en && m_up && (m_cnt == m_per);
      if (cnt_en) begin
        if (m_up) begin
          if (m_cnt <= m_per) t_cnt = m_cnt + 1; else t_cnt = m_cnt - 1;
          if (m_cnt >= m_per) t_up = 0;
        end else begin
          t_cnt = (m_cnt == 0) ? 1 : m_cnt - 1;
          if (m_cnt <= 1) t_up = 1;
        end
      end
      if (wr_en) begin
        if (addr == 0) t_per = int'(wdata);
        if (addr >= 1 && addr <= 3) t_cmp[addr-1] = int'(wdata);
        if (addr >= 4 && addr <= 6) t_buf[addr-4] = int'(wdata);
        if (addr == 7) begin
          t_mode = int'(wdata[1:0]);
          if (!wdata[2]) t_flag = 0;
        end
      end
      if (t_set) begin
        t_flag = 1;
        if (m_mode == 3) for (int i = 0; i < 3; i++) t_cmp[i] = m_buf[i];
      end
      m_cnt = t_cnt; m_up = t_up; m_per = t_per; m_mode = t_mode; m_flag = t_flag;
      for (int i = 0; i < 3; i++) begin m_cmp[i] = t_cmp[i]; m_buf[i] = t_buf[i]; end
    end
    #1;
    if (!done) begin
      chk(cur_tag, "rdata", int'(rdata), exp_rd(int'(addr)));
      chk(cur_tag, "flag", int'(match_flag), int'(m_flag));
      for (int i = 0; i < 3; i++) begin
        chk("R8", "phase_hi", int'(phase_hi[i]), (m_cnt > m_cmp[i]) ? 1 : 0);
        chk("R8", "phase_lo", int'(phase_lo[i]), (m_cnt > m_cmp[i]) ? 0 : 1);
      end
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1; addr = 4'(a); wdata = W'(d);
    @(negedge clk);
    wr_en = 0; addr = 4'd8; wdata = '0;
  endtask

  task automatic rd(int a);
    addr = 4'(a);
    @(negedge clk);
    addr = 4'd8;
  endtask

  task automatic wait_top();
    while (!(m_up && m_cnt == m_per && cnt_en)) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cnt_en = 0; wr_en = 0; addr = 4'd8; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9", "count", int'(rdata), 0);
    chk("R9", "flag", int'(match_flag), 0);
    chk("R9", "phase_lo", int'(phase_lo), 7);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R10";
    wr(0, 5); wr(1, 1); wr(2, 3); wr(3, 5);
    wr(4, 2); wr(5, 4); wr(6, 0);
    for (int a = 0; a < 16; a++) rd(a);
    wr(12, 77); rd(12);

    cur_tag = "R2"; cnt_en = 1;
    repeat (14) @(negedge clk);
    cur_tag = "R4";
    repeat (12) @(negedge clk);

    cur_tag = "R5";
    wr(7, 4);
    repeat (2) @(negedge clk);
    wr(7, 0);
    repeat (4) @(negedge clk);
    wait_top(); wr(7, 0);
    repeat (3) @(negedge clk);

    cur_tag = "R1"; cnt_en = 0;
    repeat (5) @(negedge clk);
    cnt_en = 1;
    repeat (3) @(negedge clk);

    cur_tag = "R6";
    wr(7, 3);
    repeat (15) @(negedge clk);
    wr(4, 6); wr(5, 1); wr(6, 3);
    repeat (15) @(negedge clk);
    wait_top(); wr(1, 9);
    repeat (2) @(negedge clk);
    wait_top(); wr(5, 2);
    repeat (4) @(negedge clk);
    rd(1); rd(2); rd(3);
    wait_top(); wr(7, 3);
    repeat (12) @(negedge clk);

    cur_tag = "R7";
    wr(7, 1);
    wr(4, 0); wr(5, 5); wr(6, 6);
    repeat (20) @(negedge clk);
    wr(2, 0);
    repeat (3) @(negedge clk);
    rd(1); rd(2); rd(3);
    wr(7, 2);
    repeat (14) @(negedge clk);

    cur_tag = "R11";
    while (!(m_up && m_cnt >= 4)) @(negedge clk);
    wr(0, 2);
    repeat (10) @(negedge clk);

    cur_tag = "R3";
    wr(0, 0);
    repeat (8) @(negedge clk);
    wr(0, 3);
    repeat (12) @(negedge clk);

    finish_run();
  end
endmodule